// File: doc/BRIEF.md
# Board Control Register Bank

A memory-mapped register bank for a development board's system controller, reached over a simple 32-bit read/write bus. It drives an 8-LED bar and an 8-character ASCII display buffer. The buffer can be loaded in two ways: a single 32-bit word written once becomes eight uppercase hexadecimal digits, or each character can be written through its own position register. The bank also holds a general-purpose output byte and the I2C output-enable and select bits. It returns a fixed switch value and raises a soft-reset request.

The bank also connects the bus to a bit-banged I2C interface. A write to the I2C output register drives the clock and data lines. A read of the I2C input register returns the live data level from the I2C device. Only the low 20 address bits take part in decoding, so the whole bank appears again at every 1 MiB of address space.

A bus access is a single cycle with `req_i` high. For a write, `we_i` is high and the write takes effect at that clock edge. For a read, `we_i` is low and `rdata_o`, `rvalid_o` and `bad_addr_o` are registered, so they are valid during the following cycle only.

Top module: `board_ctl`

## Requirements
- R1: Decoding uses only address bits [19:0]. An access whose upper address bits differ reaches the same register as one with those bits zero.
- R2: The LED register (offset 0x008) stores bits [7:0] of the write data on `led_o`. A read returns those 8 bits zero-extended.
- R3: A write to the word register (offset 0x010) replaces all eight characters with the data rendered as uppercase hexadecimal ASCII (0x30-0x39 for 0-9, 0x41-0x46 for A-F). Character 0 holds data bits [31:28] and character 7 holds bits [3:0]. Character k is `disp_o[8k+7:8k]`.
- R4: Character k has its own register at offset 0x418 + 8*k, for k in 0..7. A write stores bits [7:0] of the data into that character only, and a read returns it. Offsets inside the 8-byte stride that are not multiples of 8 are unmapped.
- R5: The switch register (offset 0x000) always reads zero, and writes to it have no effect.
- R6: The general-purpose output register (0x020) keeps 8 bits, the I2C output-enable register (0x028) keeps 2 bits and the I2C select register (0x040) keeps 1 bit. Each drives its output, and reads return only the kept bits.
- R7: A write to the I2C output register (0x030) drives `scl_o` from data bit 1 and `sda_o` from data bit 0. A read of 0x030 returns {scl, sda} in bits [1:0].
- R8: A read of the I2C input register (0x038) returns the driven SCL level in bit 1 and the level of `sda_i` at the read edge in bit 0. All other bits read zero.
- R9: After reset, every character is 0x20 (space), `led_o`, `gpo_o`, `i2c_oe_o` and `i2c_sel_o` are zero, `scl_o` and `sda_o` are one, and `rst_req_o`, `rvalid_o` and `bad_addr_o` are zero.
- R10: A write of exactly 0x00000042 to the soft-reset register (0x018) raises `rst_req_o` for one cycle after the write edge. A write of any other value leaves it low.
- R11: A read of an unmapped offset returns zero with `bad_addr_o` high for that one result cycle. Reads of mapped offsets leave `bad_addr_o` low. Writes to unmapped offsets change no output.
- R12: A read request produces `rvalid_o` high, with its data, in the cycle after the request edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read result valid |
| bad_addr_o | output | 1 | Read hit an unmapped offset |
| led_o | output | 8 | LED bar |
| disp_o | output | 64 | Display buffer, character k at bits [8k+7:8k] |
| gpo_o | output | 8 | General-purpose output |
| i2c_oe_o | output | 2 | I2C output enables |
| i2c_sel_o | output | 1 | I2C select |
| scl_o | output | 1 | I2C clock level |
| sda_o | output | 1 | I2C data level driven |
| sda_i | input | 1 | I2C data level from the device |
| rst_req_o | output | 1 | Soft-reset request pulse |

## Verification
Write effects (`led_o`, `disp_o`, `gpo_o`, the I2C outputs and `rst_req_o`) register at the write edge and are due one cycle later. Read results are due in the cycle after the request edge. Each bus task drives the request at a falling edge and samples at the next falling edge, so every result is read half a cycle after the edge that produced it. The soft-reset pulse is sampled at that point and again one cycle later to confirm it lasts exactly one cycle.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int unsigned OFF_SW     = 32'h000;
  localparam int unsigned OFF_LED    = 32'h008;
  localparam int unsigned OFF_WORD   = 32'h010;
  localparam int unsigned OFF_SRST   = 32'h018;
  localparam int unsigned OFF_GPO    = 32'h020;
  localparam int unsigned OFF_I2C_OE = 32'h028;
  localparam int unsigned OFF_I2C_WR = 32'h030;
  localparam int unsigned OFF_I2C_RD = 32'h038;
  localparam int unsigned OFF_I2C_SL = 32'h040;
  localparam int unsigned OFF_CHAR0  = 32'h418;
  localparam int unsigned CHAR_SH    = 3;
  localparam logic [31:0] SRST_KEY   = 32'h0000_0042;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SW, SEL_LED, SEL_WORD, SEL_SRST, SEL_GPO,
    SEL_OE, SEL_I2C_WR, SEL_I2C_RD, SEL_I2C_SL, SEL_CHAR
  } reg_sel_e;

  function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
    return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
  endfunction

  function automatic logic is_hex_ascii(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46);
  endfunction

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int unsigned DEC_W = 20,
  parameter int unsigned NCHAR = 8,
  parameter int unsigned IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic [DEC_W-1:0] off_i,
  output reg_sel_e         sel_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [DEC_W-1:0] CHAR_BASE = DEC_W'(OFF_CHAR0);
  localparam logic [DEC_W-1:0] CHAR_SPAN = DEC_W'(NCHAR << CHAR_SH);

  logic [DEC_W-1:0] diff;
  logic             in_char;
  logic             unused_diff;

  assign diff    = off_i - CHAR_BASE;
  assign in_char = (off_i >= CHAR_BASE) && (diff < CHAR_SPAN) &&
                   (off_i[CHAR_SH-1:0] == '0);
  assign idx_o   = diff[CHAR_SH +: IDX_W];
  assign unused_diff = ^{diff[CHAR_SH-1:0], diff[DEC_W-1:CHAR_SH+IDX_W]};

  always_comb begin
    sel_o = SEL_NONE;
    if (in_char) sel_o = SEL_CHAR;
    else begin
      unique case (off_i)
        DEC_W'(OFF_SW):     sel_o = SEL_SW;
        DEC_W'(OFF_LED):    sel_o = SEL_LED;
        DEC_W'(OFF_WORD):   sel_o = SEL_WORD;
        DEC_W'(OFF_SRST):   sel_o = SEL_SRST;
        DEC_W'(OFF_GPO):    sel_o = SEL_GPO;
        DEC_W'(OFF_I2C_OE): sel_o = SEL_OE;
        DEC_W'(OFF_I2C_WR): sel_o = SEL_I2C_WR;
        DEC_W'(OFF_I2C_RD): sel_o = SEL_I2C_RD;
        DEC_W'(OFF_I2C_SL): sel_o = SEL_I2C_SL;
        default:            sel_o = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/board_ctl_disp.sv
module board_ctl_disp
  import board_ctl_pkg::*;
#(
  parameter int unsigned NCHAR = 8,
  parameter int unsigned IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_we_i,
  input  logic [4*NCHAR-1:0] word_i,
  input  logic               char_we_i,
  input  logic [IDX_W-1:0]   char_idx_i,
  input  logic [7:0]         char_i,
  output logic [8*NCHAR-1:0] disp_o
);

  for (genvar g = 0; g < NCHAR; g++) begin : g_char
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        disp_o[8*g +: 8] <= 8'h20;
      end else if (word_we_i) begin
        // leftmost character takes the most significant nibble
        disp_o[8*g +: 8] <= hex_ascii(word_i[4*(NCHAR-1-g) +: 4]);
      end else if (char_we_i && char_idx_i == IDX_W'(g)) begin
        disp_o[8*g +: 8] <= char_i;
      end
    end

    // R3
    word_hex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_we_i |=> is_hex_ascii(disp_o[8*g +: 8]));
  end

endmodule

// File: rtl/board_ctl.sv
module board_ctl
  import board_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEC_W  = 20,
  parameter int unsigned NCHAR  = 8,
  parameter int unsigned LED_W  = 8,
  parameter int unsigned GPO_W  = 8,
  parameter int unsigned OE_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic               bad_addr_o,
  output logic [LED_W-1:0]   led_o,
  output logic [8*NCHAR-1:0] disp_o,
  output logic [GPO_W-1:0]   gpo_o,
  output logic [OE_W-1:0]    i2c_oe_o,
  output logic               i2c_sel_o,
  output logic               scl_o,
  output logic               sda_o,
  input  logic               sda_i,
  output logic               rst_req_o
);

  localparam int unsigned IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1;

  reg_sel_e         sel;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_addr;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;
  assign unused_addr = ^addr_i[ADDR_W-1:DEC_W];

  board_ctl_decode #(.DEC_W(DEC_W), .NCHAR(NCHAR), .IDX_W(IDX_W)) u_decode (
    .off_i (addr_i[DEC_W-1:0]),
    .sel_o (sel),
    .idx_o (idx)
  );

  board_ctl_disp #(.NCHAR(NCHAR), .IDX_W(IDX_W)) u_disp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_we_i  (wr && sel == SEL_WORD),
    .word_i     (wdata_i[4*NCHAR-1:0]),
    .char_we_i  (wr && sel == SEL_CHAR),
    .char_idx_i (idx),
    .char_i     (wdata_i[7:0]),
    .disp_o     (disp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_o     <= '0;
      gpo_o     <= '0;
      i2c_oe_o  <= '0;
      i2c_sel_o <= 1'b0;
      scl_o     <= 1'b1;
      sda_o     <= 1'b1;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= wr && sel == SEL_SRST && wdata_i == DATA_W'(SRST_KEY);
      if (wr) begin
        unique case (sel)
          SEL_LED:    led_o     <= wdata_i[LED_W-1:0];
          SEL_GPO:    gpo_o     <= wdata_i[GPO_W-1:0];
          SEL_OE:     i2c_oe_o  <= wdata_i[OE_W-1:0];
          SEL_I2C_SL: i2c_sel_o <= wdata_i[0];
          SEL_I2C_WR: begin
            scl_o <= wdata_i[1];
            sda_o <= wdata_i[0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LED:    rd_mux = DATA_W'(led_o);
      SEL_GPO:    rd_mux = DATA_W'(gpo_o);
      SEL_OE:     rd_mux = DATA_W'(i2c_oe_o);
      SEL_I2C_SL: rd_mux = DATA_W'(i2c_sel_o);
      SEL_I2C_WR: rd_mux = DATA_W'({scl_o, sda_o});
      SEL_I2C_RD: rd_mux = DATA_W'({scl_o, sda_i});
      SEL_CHAR:   rd_mux = DATA_W'(disp_o[8*idx +: 8]);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
      bad_addr_o <= 1'b0;
    end else begin
      rvalid_o   <= rd;
      bad_addr_o <= rd && sel == SEL_NONE;
      rdata_o    <= rd ? rd_mux : '0;
    end
  end

  // R12
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R11
  bad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr_o |-> (rvalid_o && rdata_o == '0));

  // R10
  srst_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(req_i && we_i && wdata_i == DATA_W'(SRST_KEY)));

  // R2
  led_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(led_o));

endmodule

// File: tb/board_ctl_bench.sv
module board_ctl_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, bad_addr_o;
  logic [7:0]  led_o, gpo_o;
  logic [63:0] disp_o;
  logic [1:0]  i2c_oe_o;
  logic        i2c_sel_o, scl_o, sda_o, rst_req_o;
  logic        sda_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  board_ctl u_board_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .bad_addr_o(bad_addr_o), .led_o(led_o),
    .disp_o(disp_o), .gpo_o(gpo_o), .i2c_oe_o(i2c_oe_o),
    .i2c_sel_o(i2c_sel_o), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i),
    .rst_req_o(rst_req_o)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 32'h0000_0008, 32'h0000_01A5, 32'h0,          8'd2},  // R2
    '{1'b0, 32'h0000_0008, 32'h0,         32'h0000_00A5, 8'd2},  // R2
    '{1'b0, 32'hFFF0_0008, 32'h0,         32'h0000_00A5, 8'd1},  // R1
    '{1'b1, 32'h00A0_0020, 32'h0000_1234, 32'h0,          8'd1},  // R1
    '{1'b0, 32'h0000_0020, 32'h0,         32'h0000_0034, 8'd6},  // R6
    '{1'b1, 32'h0000_0028, 32'h0000_000F, 32'h0,          8'd6},  // R6
    '{1'b0, 32'h0000_0028, 32'h0,         32'h0000_0003, 8'd6},  // R6
    '{1'b1, 32'h0000_0040, 32'h0000_0003, 32'h0,          8'd6},  // R6
    '{1'b0, 32'h0000_0040, 32'h0,         32'h0000_0001, 8'd6},  // R6
    '{1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0,          8'd5},  // R5
    '{1'b0, 32'h0000_0000, 32'h0,         32'h0000_0000, 8'd5},  // R5
    '{1'b1, 32'h0000_0030, 32'h0000_0002, 32'h0,          8'd7},  // R7
    '{1'b0, 32'h0000_0030, 32'h0,         32'h0000_0002, 8'd7},  // R7
    '{1'b0, 32'h0000_0038, 32'h0,         32'h0000_0003, 8'd8},  // R8
    '{1'b1, 32'h0000_0448, 32'h0000_0161, 32'h0,          8'd4},  // R4
    '{1'b0, 32'h0000_0448, 32'h0,         32'h0000_0061, 8'd4}   // R4
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d,
                        output logic v, output logic b);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    d = rdata_o; v = rvalid_o; b = bad_addr_o;
    req_i = 1'b0;
  endtask

  function automatic logic [63:0] hex_disp(input logic [31:0] w);
    string hs = "0123456789ABCDEF";
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = hs[w[31-4*k -: 4]];
    return r;
  endfunction

  initial begin
    logic [31:0] d;
    logic v, b;
    logic [63:0] exp_disp;
    logic [7:0]  led_prev;

    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(disp_o == {8{8'h20}}, "R9 disp", disp_o, {8{8'h20}});
    chk(led_o == 8'h0 && gpo_o == 8'h0, "R9 led/gpo", {led_o, gpo_o}, 0);
    chk(i2c_oe_o == 2'b0 && !i2c_sel_o, "R9 oe/sel", {i2c_oe_o, i2c_sel_o}, 0);
    chk(scl_o && sda_o, "R9 scl/sda", {scl_o, sda_o}, 2'b11);
    chk(!rst_req_o && !rvalid_o && !bad_addr_o, "R9 pulses",
        {rst_req_o, rvalid_o, bad_addr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!rvalid_o, "R12 idle", rvalid_o, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) bus_wr(VEC[i].addr, VEC[i].data);
      else begin
        bus_rd(VEC[i].addr, d, v, b);
        n_chk++;
        if (d !== VEC[i].exp || !v || b) begin
          n_fail++;
          $display("FAIL R%0d vec %0d actual=%h/%b/%b expected=%h/1/0",
                   VEC[i].rq, i, d, v, b, VEC[i].exp);
        end
      end
    end
    // R2 R6 R7 outputs after table
    chk(led_o == 8'hA5, "R2 led_o", led_o, 8'hA5);
    chk(gpo_o == 8'h34 && i2c_oe_o == 2'd3 && i2c_sel_o, "R6 outputs",
        {gpo_o, i2c_oe_o, i2c_sel_o}, {8'h34, 2'd3, 1'b1});
    chk(scl_o && !sda_o, "R7 lines", {scl_o, sda_o}, 2'b10);

    // R8 follows sda_i
    sda_i = 1'b0;
    bus_rd(32'h38, d, v, b);
    chk(d == 32'h2, "R8 sda low", d, 32'h2);
    bus_wr(32'h30, 32'h1);
    sda_i = 1'b1;
    bus_rd(32'h38, d, v, b);
    chk(d == 32'h1, "R8 scl low", d, 32'h1);
    chk(!scl_o && sda_o, "R7 lines 01", {scl_o, sda_o}, 2'b01);

    // R3 word writes
    bus_wr(32'h10, 32'h1234_ABCD);
    exp_disp = hex_disp(32'h1234_ABCD);
    chk(disp_o == exp_disp, "R3 word1", disp_o, exp_disp);
    bus_rd(32'h418, d, v, b);
    chk(d == 32'h31, "R4 char0", d, 32'h31);
    bus_rd(32'h450, d, v, b);
    chk(d == 32'h44, "R4 char7", d, 32'h44);
    // R4 single char write leaves others intact
    bus_wr(32'h430, 32'h0001_FF5A);
    exp_disp[31:24] = 8'h5A;
    chk(disp_o == exp_disp, "R4 char3", disp_o, exp_disp);
    bus_wr(32'h10, 32'h09F0_E7C6);
    exp_disp = hex_disp(32'h09F0_E7C6);
    chk(disp_o == exp_disp, "R3 word2", disp_o, exp_disp);

    // R10 soft reset
    bus_wr(32'h18, 32'h42);
    chk(rst_req_o, "R10 pulse", rst_req_o, 1);
    @(negedge clk_i);
    chk(!rst_req_o, "R10 one cycle", rst_req_o, 0);
    bus_wr(32'h18, 32'h142);
    chk(!rst_req_o, "R10 wrong key", rst_req_o, 0);

    // R11 unmapped accesses
    bus_rd(32'h100, d, v, b);
    chk(b && v && d == 0, "R11 bad read", {d, v, b}, {32'h0, 2'b11});
    @(negedge clk_i);
    chk(!bad_addr_o && !rvalid_o, "R12 single cycle", {bad_addr_o, rvalid_o}, 0);
    bus_rd(32'h41C, d, v, b);
    chk(b && d == 0, "R11 misaligned char", {d, b}, {32'h0, 1'b1});
    bus_rd(32'h8, d, v, b);
    chk(!b && v, "R11 mapped no flag", {v, b}, 2'b10);
    led_prev = led_o;
    bus_wr(32'h104, 32'hFFFF_FFFF);
    chk(led_o == led_prev && disp_o == exp_disp && gpo_o == 8'h34,
        "R11 bad write", {led_o, gpo_o}, {led_prev, 8'h34});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule